// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Channel

This block is one input-capture channel. It watches an asynchronous external pin, brings it into the clock domain, and looks for the edge type chosen by a two-bit mode field. When that edge arrives, it copies the free-running 16-bit timer count into a capture register and sends a one-cycle event pulse to the flag logic. Capture can also be limited to a single event. In that case the channel records one edge and then refuses further edges until software writes the control register again.

Software reaches the channel through an 8-bit register port. Reading the low byte of the capture value latches the high byte. The next high-byte read returns that latched byte and releases the latch, so a two-byte read stays consistent even if a capture happens between the two accesses. A test bit holds the capture register at all ones for as long as the bit is set.

Top module: `cap_channel`

## Requirements
- R1: The edge mode is held in control bits [1:0] at address 0. The encodings are: 00 captures nothing, 01 captures on a rising edge, 10 captures on a falling edge, 11 captures on both edges.
- R2: An accepted edge loads `tmr_cnt_i` into the capture register and pulses `cap_evt_o` high for exactly one cycle. The pin passes through a two-flop synchronizer, and the edge is found by comparing the synchronized level with its value one cycle earlier.
- R3: Reading address 1 returns capture bits [7:0]. Reading address 2 returns capture bits [15:8]. Reading address 0 returns {3'b000, lock_status, force, lock_enable, mode[1:0]}.
- R4: A read of address 1 latches capture bits [15:8]. The next read of address 2 returns that latched byte, whatever delay separates the two reads, and then releases the latch.
- R5: A capture that occurs while the latch is held still updates the live capture register, but it does not change the latched high byte.
- R6: When control bit 2 (lock enable) is set, the first accepted edge sets the lock status. While the lock status is set, edges cause no capture and no event. Any write to address 0 clears the lock status. If a capture and a write fall in the same cycle, the capture's lock takes priority.
- R7: While control bit 3 is set, the capture register reads 16'hFFFF. After the bit is cleared, the register keeps that value until the next capture.
- R8: A mode write that makes an edge already in flight match the new mode causes a capture. That capture behaves like any other, including setting the lock.
- R9: After reset, the control register, the lock status and the capture register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_cnt_i | input | 16 | Free-running timer count |
| pin_i | input | 1 | Asynchronous external capture input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| cap_evt_o | output | 1 | One-cycle capture event pulse |

## Verification
The pin is driven with rising, falling and double transitions in each of the four modes. Each mode must react to exactly its own polarity and ignore the other one, which the event count and the captured value show. Capture values such as 16'h1234 and 16'hAA55 have distinct bytes, so a swapped byte lane or a stale latched byte shows up on readback. In further sequences a capture lands between the two byte reads, a second edge arrives while the lock is set, the force bit is set and then cleared, and a mode write coincides with an edge already in the synchronizer.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       force_ones;
    logic       lock_en;
    edge_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  cap_pkg::edge_mode_e mode_i,
  output logic               trig_o
);
  import cap_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: trig_o = lvl & ~prev_q;
      EDGE_FALL: trig_o = ~lvl & prev_q;
      EDGE_BOTH: trig_o = lvl ^ prev_q;
      default:   trig_o = 1'b0;
    endcase
  end

  // R2: a trigger only ever comes from a change seen at the synchronizer output
  a_r2_trig_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (lvl != prev_q));
  // R1: a rising-only mode never fires on a falling transition
  a_r1_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && mode_i == EDGE_RISE) |-> lvl);
endmodule

// File: rtl/cap_store.sv
module cap_store (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      trig_i,
  input  logic                      lock_en_i,
  input  logic                      force_i,
  input  logic                      ctrl_wr_i,
  input  logic [cap_pkg::CNT_W-1:0] tmr_i,
  output logic [cap_pkg::CNT_W-1:0] cap_o,
  output logic                      locked_o,
  output logic                      evt_o
);
  import cap_pkg::*;

  logic [CNT_W-1:0] cap_q;
  logic             locked_q, evt_q, accept;

  assign accept = trig_i & ~locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= '0;
      locked_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= accept;
      if (force_i)     cap_q <= '1;
      else if (accept) cap_q <= tmr_i;
      // capture's lock wins over a simultaneous control write
      if (accept && lock_en_i) locked_q <= 1'b1;
      else if (ctrl_wr_i)      locked_q <= 1'b0;
    end
  end

  assign cap_o    = cap_q;
  assign locked_o = locked_q;
  assign evt_o    = evt_q;

  a_r2_evt_loads_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !$past(force_i)) |-> cap_q == $past(tmr_i));
  a_r6_lock_blocks_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> !evt_q);
  a_r7_force_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(force_i) |-> cap_q == '1);
  a_r2_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && lock_en_i && !ctrl_wr_i) |=> !evt_q);
endmodule

// File: rtl/cap_rd_port.sv
module cap_rd_port (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic [cap_pkg::ADDR_W-1:0] addr_i,
  input  logic [cap_pkg::CNT_W-1:0]  cap_i,
  input  logic [cap_pkg::BYTE_W-1:0] ctrl_i,
  output logic [cap_pkg::BYTE_W-1:0] rdata_o
);
  import cap_pkg::*;

  logic [BYTE_W-1:0] hi_frz_q;
  logic              frz_q, rd_lo, rd_hi;

  assign rd_lo = rd_i && (addr_i == ADR_LO);
  assign rd_hi = rd_i && (addr_i == ADR_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_frz_q <= '0;
      frz_q    <= 1'b0;
    end else if (rd_lo) begin
      hi_frz_q <= cap_i[CNT_W-1:BYTE_W];
      frz_q    <= 1'b1;
    end else if (rd_hi) begin
      frz_q    <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADR_CTRL: rdata_o = ctrl_i;
      ADR_LO:   rdata_o = cap_i[BYTE_W-1:0];
      ADR_HI:   rdata_o = frz_q ? hi_frz_q : cap_i[CNT_W-1:BYTE_W];
      default:  rdata_o = '0;
    endcase
  end

  a_r4_lo_latches_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> (frz_q && hi_frz_q == $past(cap_i[CNT_W-1:BYTE_W])));
  a_r5_frozen_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !rd_lo) |=> $stable(hi_frz_q));
  a_r4_hi_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi && !rd_lo) |=> !frz_q);
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] tmr_cnt_i,
  input  logic        pin_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        cap_evt_o
);
  import cap_pkg::*;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              ctrl_wr, trig, locked;
  logic [CNT_W-1:0]  cap;
  logic [BYTE_W-1:0] ctrl_rd;

  assign ctrl_wr = bus_wr_i && (bus_addr_i == ADR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);

  assign ctrl_rd = {{(BYTE_W-CTRL_W-1){1'b0}}, locked, ctrl_q};

  cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .mode_i (ctrl_q.mode),
    .trig_o (trig)
  );

  cap_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .lock_en_i (ctrl_q.lock_en),
    .force_i   (ctrl_q.force_ones),
    .ctrl_wr_i (ctrl_wr),
    .tmr_i     (tmr_cnt_i),
    .cap_o     (cap),
    .locked_o  (locked),
    .evt_o     (cap_evt_o)
  );

  cap_rd_port u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .cap_i   (cap),
    .ctrl_i  (ctrl_rd),
    .rdata_o (bus_rdata_o)
  );

  // R6/R8: capture with lock enabled leaves the channel locked even across a control write
  a_r8_lock_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !locked && ctrl_q.lock_en) |=> locked);
  a_r1_none_no_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode == EDGE_NONE) |=> !cap_evt_o);
endmodule

// File: tb/tb_cap_channel.sv
module tb_cap_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr = '0;
  logic        pin = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        evt;

  int checks = 0, errors = 0, evt_cnt = 0, cycles = 0;

  always #5 clk = ~clk;

  cap_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_cnt_i(tmr), .pin_i(pin),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cap_evt_o(evt)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst_n && evt) evt_cnt++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(2'd1, lo);
    bus_read(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk); pin = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] c;
    bus_read(2'd0, d);  check("R9 ctrl", d, 8'h00);
    read_cap(c);        check("R9 cap", c, 16'h0000);
    check("R9 evt", evt, 0);
  endtask

  task automatic t_rise;
    logic [15:0] c; int e0;
    bus_write(2'd0, 8'h01);
    tmr = 16'h1234; e0 = evt_cnt;
    drive_pin(1'b1);
    check("R2 rise evt", evt_cnt - e0, 1);
    read_cap(c); check("R3 rise value", c, 16'h1234);
    tmr = 16'hBEEF; drive_pin(1'b0);
    check("R1 rise ignores fall", evt_cnt - e0, 1);
    read_cap(c); check("R1 rise keeps value", c, 16'h1234);
  endtask

  task automatic t_fall;
    logic [15:0] c; int e0;
    bus_write(2'd0, 8'h02);
    tmr = 16'h0F0F; e0 = evt_cnt;
    drive_pin(1'b1);
    check("R1 fall ignores rise", evt_cnt - e0, 0);
    tmr = 16'hAA55; drive_pin(1'b0);
    check("R1 fall evt", evt_cnt - e0, 1);
    read_cap(c); check("R2 fall value", c, 16'hAA55);
  endtask

  task automatic t_both;
    logic [15:0] c; int e0;
    bus_write(2'd0, 8'h03);
    e0 = evt_cnt;
    tmr = 16'h1357; drive_pin(1'b1);
    read_cap(c); check("R1 both rise value", c, 16'h1357);
    tmr = 16'h2468; drive_pin(1'b0);
    read_cap(c); check("R1 both fall value", c, 16'h2468);
    check("R1 both evt count", evt_cnt - e0, 2);
  endtask

  task automatic t_none;
    logic [15:0] c; int e0;
    bus_write(2'd0, 8'h00);
    e0 = evt_cnt;
    tmr = 16'h7777; drive_pin(1'b1); drive_pin(1'b0);
    check("R1 none evt", evt_cnt - e0, 0);
    read_cap(c); check("R1 none value", c, 16'h2468);
  endtask

  task automatic t_freeze;
    logic [7:0] lo, hi; logic [15:0] c;
    bus_write(2'd0, 8'h01);
    tmr = 16'hAA11; drive_pin(1'b1);
    bus_read(2'd1, lo); check("R3 lo byte", lo, 8'h11);
    tmr = 16'h5522; drive_pin(1'b0); drive_pin(1'b1);
    bus_read(2'd2, hi); check("R5 frozen hi", hi, 8'hAA);
    read_cap(c); check("R5 live after release", c, 16'h5522);
    drive_pin(1'b0);
  endtask

  task automatic t_lock;
    logic [7:0] d; logic [15:0] c; int e0;
    bus_write(2'd0, 8'h07);
    e0 = evt_cnt;
    tmr = 16'h1111; drive_pin(1'b1);
    bus_read(2'd0, d); check("R6 locked status", d, 8'h17);
    tmr = 16'h2222; drive_pin(1'b0);
    check("R6 locked no evt", evt_cnt - e0, 1);
    read_cap(c); check("R6 locked keeps value", c, 16'h1111);
    bus_write(2'd0, 8'h07);
    bus_read(2'd0, d); check("R6 write unlocks", d, 8'h07);
    tmr = 16'h3333; drive_pin(1'b1);
    read_cap(c); check("R6 capture after unlock", c, 16'h3333);
    bus_write(2'd0, 8'h00);
    drive_pin(1'b0);
  endtask

  task automatic t_force;
    logic [15:0] c;
    bus_write(2'd0, 8'h08);
    read_cap(c); check("R7 forced ones", c, 16'hFFFF);
    bus_write(2'd0, 8'h01);
    read_cap(c); check("R7 held after release", c, 16'hFFFF);
    tmr = 16'h4444; drive_pin(1'b1);
    read_cap(c); check("R7 capture after force", c, 16'h4444);
    bus_write(2'd0, 8'h00);
    drive_pin(1'b0);
  endtask

  task automatic t_spurious;
    logic [7:0] d; logic [15:0] c; int e0;
    e0 = evt_cnt;
    tmr = 16'h6789;
    @(negedge clk); pin = 1'b1;
    @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 8'h05;
    @(negedge clk); wr = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 spurious evt", evt_cnt - e0, 1);
    read_cap(c); check("R8 spurious value", c, 16'h6789);
    bus_read(2'd0, d); check("R8 spurious lock", d, 8'h15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_none();
    t_freeze();
    t_lock();
    t_force();
    t_spurious();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule